// File: doc/BRIEF.md
# Eight-bit Arithmetic and Logic Unit with Status Flags

This block is the purely combinational datapath of an 8-bit accumulator processor. In one evaluation it takes an operation code, a register operand, a memory operand and the current condition flags. It returns a data result, a full set of next flags and a per-flag write mask. The surrounding sequencer latches the result into the destination register. It loads the flag outputs into its status register without extra logic, because flags the operation leaves alone come back unchanged.

The flag vector is four bits wide, ordered negative, overflow, zero, carry at bits 3, 2, 1 and 0. The write mask uses the same ordering. Unary operations (shifts, rotates, increment, decrement, register transfer) act on the register operand. A caller that works on a memory byte routes that byte onto the register port. Only binary arithmetic is provided; there is no decimal mode. The block has no clock and no state, and it contains no state machine: the operation code alone picks the behaviour.

Top module: `alu8_core`

## Requirements
- R1: Operation 0 (add) returns reg + mem + C modulo 256. C is set when the true sum exceeds 255. V is set when the signed sum lies outside -128..127. N and Z follow the result, and the mask is 1111.
- R2: Operation 1 (subtract) returns reg - mem - (1 - C) modulo 256. C is set when no borrow occurs, meaning the exact difference is not negative. V is set when the signed difference lies outside -128..127. N and Z follow the result, and the mask is 1111.
- R3: Operation 5 (compare) returns reg unchanged. C is set when reg >= mem and Z is set when they are equal. N is bit 7 of reg - mem modulo 256. The mask is 1011.
- R4: Operation 6 (bit test) returns reg unchanged. It copies mem bit 7 into N and mem bit 6 into V, and sets Z when reg AND mem is zero. The mask is 1110.
- R5: Operations 2, 3 and 4 return reg OR mem, reg AND mem and reg XOR mem. N and Z follow the result, and the mask is 1010.
- R6: Operation 7 shifts reg left, filling bit 0 with zero and moving old bit 7 into C. Operation 8 shifts reg right, filling bit 7 with zero and moving old bit 0 into C. N and Z follow the result, and the mask is 1011.
- R7: Operation 9 rotates reg left through carry, placing the old C into bit 0. Operation 10 rotates reg right through carry, placing the old C into bit 7. The bit shifted out becomes the new C. The mask is 1011.
- R8: Operations 11 and 12 return reg + 1 and reg - 1 modulo 256, so 255 becomes 0 and 0 becomes 255. N and Z follow the result, and the mask is 1010.
- R9: Operation 13 (load) returns mem and operation 15 (transfer) returns reg. N and Z follow the result, and the mask is 1010.
- R10: Operation 14 (quiet move, used for writes into the stack pointer) returns reg. It changes no flag, and the mask is 0000.
- R11: For every operation, each flag whose mask bit is 0 equals the incoming flag bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| reg_i | input | 8 | Register operand (accumulator, index or routed memory byte) |
| mem_i | input | 8 | Memory operand |
| flg_i | input | 4 | Incoming flags {N,V,Z,C} |
| res_o | output | 8 | Data result |
| flg_o | output | 4 | Next flags {N,V,Z,C} |
| fwe_o | output | 4 | Flag write mask {N,V,Z,C} |

## Verification
Carry-out and signed overflow can both be set by the same add or subtract. They can also arise together with a zero result, as when 0x80 + 0x80 gives carry, overflow and zero together. The sweep covers every register value against a spread of memory values that includes 0x00, 0x7F, 0x80 and 0xFF, with both values of the incoming carry, so all combinations of these flags appear. Each combination is judged against signed and unsigned integer arithmetic done in the bench. In the same evaluation the bench confirms that masked-off flags repeat the incoming pattern, which it varies with the operands.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_OR    = 4'd2,
        OP_AND   = 4'd3,
        OP_XOR   = 4'd4,
        OP_CMP   = 4'd5,
        OP_BIT   = 4'd6,
        OP_SHL   = 4'd7,
        OP_SHR   = 4'd8,
        OP_ROL   = 4'd9,
        OP_ROR   = 4'd10,
        OP_INC   = 4'd11,
        OP_DEC   = 4'd12,
        OP_LOAD  = 4'd13,
        OP_QUIET = 4'd14,
        OP_XFER  = 4'd15
    } alu_op_e;

    localparam int FLAG_N = 3;
    localparam int FLAG_V = 2;
    localparam int FLAG_Z = 1;
    localparam int FLAG_C = 0;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   m,
    input  logic           cin,
    output logic [W-1:0]   sum,
    output logic           cout,
    output logic           ovf
);
    localparam int MSB = W - 1;

    logic [W-1:0] addend;
    logic         carry_in;
    logic [W:0]   wide;

    always_comb begin
        unique case (op)
            OP_ADD:  begin addend = m;           carry_in = cin;  end
            OP_SUB:  begin addend = ~m;          carry_in = cin;  end
            OP_CMP:  begin addend = ~m;          carry_in = 1'b1; end
            OP_INC:  begin addend = '0;          carry_in = 1'b1; end
            OP_DEC:  begin addend = '1;          carry_in = 1'b0; end
            default: begin addend = m;           carry_in = 1'b0; end
        endcase
        wide = {1'b0, a} + {1'b0, addend} + {{W{1'b0}}, carry_in};
        sum  = wide[W-1:0];
        cout = wide[W];
        ovf  = (a[MSB] == addend[MSB]) && (wide[MSB] != a[MSB]);
    end

    // R1: signed overflow agrees with a range test on widened signed values
    always_comb begin
        if (op == OP_ADD) begin
            a_r1_add_ovf: assert (ovf == (($signed({a[MSB], a}) + $signed({m[MSB], m})
                                 + $signed({1'b0, cin})) > $signed({2'b00, {(W-1){1'b1}}})
                                 || ($signed({a[MSB], a}) + $signed({m[MSB], m})
                                 + $signed({1'b0, cin})) < $signed({2'b11, {(W-1){1'b0}}})))
                else $error("add overflow rule broken");
        end
        // R3: compare carry is an unsigned ordering
        if (op == OP_CMP) begin
            a_r3_cmp_carry: assert (cout == (a >= m))
                else $error("compare carry does not match ordering");
        end
        // R8: increment of all-ones wraps to zero
        if (op == OP_INC && a == '1) begin
            a_r8_inc_wrap: assert (sum == '0)
                else $error("increment did not wrap");
        end
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   m,
    output logic [W-1:0]   res,
    output logic           tst_zero
);
    always_comb begin
        unique case (op)
            OP_OR:   res = a | m;
            OP_AND:  res = a & m;
            OP_XOR:  res = a ^ m;
            OP_LOAD: res = m;
            default: res = a;
        endcase
        tst_zero = ((a & m) == '0);
    end

    // R4: the bit test leaves the register value intact
    always_comb begin
        if (op == OP_BIT) begin
            a_r4_bit_keeps_reg: assert (res == a)
                else $error("bit test altered the register value");
        end
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           cout
);
    localparam int MSB = W - 1;

    logic fill_lo;
    logic fill_hi;

    always_comb begin
        fill_lo = (op == OP_ROL) ? cin : 1'b0;
        fill_hi = (op == OP_ROR) ? cin : 1'b0;
        unique case (op)
            OP_SHL, OP_ROL: begin res = {a[MSB-1:0], fill_lo}; cout = a[MSB]; end
            OP_SHR, OP_ROR: begin res = {fill_hi, a[MSB:1]};   cout = a[0];   end
            default:        begin res = a;                     cout = cin;    end
        endcase
    end

    // R7: rotates move the old carry into the vacated end
    always_comb begin
        if (op == OP_ROL) begin
            a_r7_rol_fill: assert (res[0] == cin)
                else $error("rotate left lost the carry");
        end
        if (op == OP_ROR) begin
            a_r7_ror_fill: assert (res[MSB] == cin)
                else $error("rotate right lost the carry");
        end
        // R6: logical right shift clears the top bit
        if (op == OP_SHR) begin
            a_r6_shr_top: assert (res[MSB] == 1'b0)
                else $error("logical shift right kept the top bit");
        end
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [3:0]   op_i,
    input  logic [W-1:0] reg_i,
    input  logic [W-1:0] mem_i,
    input  logic [3:0]   flg_i,
    output logic [W-1:0] res_o,
    output logic [3:0]   flg_o,
    output logic [3:0]   fwe_o
);
    localparam int MSB = W - 1;

    alu_op_e      op;
    logic [W-1:0] ar_sum;
    logic         ar_c;
    logic         ar_v;
    logic [W-1:0] lg_res;
    logic         lg_tz;
    logic [W-1:0] sh_res;
    logic         sh_c;
    logic [3:0]   nxt;

    assign op = alu_op_e'(op_i);

    alu8_arith #(.W(W)) u_arith (
        .op(op), .a(reg_i), .m(mem_i), .cin(flg_i[FLAG_C]),
        .sum(ar_sum), .cout(ar_c), .ovf(ar_v)
    );

    alu8_logic #(.W(W)) u_logic (
        .op(op), .a(reg_i), .m(mem_i), .res(lg_res), .tst_zero(lg_tz)
    );

    alu8_shift #(.W(W)) u_shift (
        .op(op), .a(reg_i), .cin(flg_i[FLAG_C]), .res(sh_res), .cout(sh_c)
    );

    always_comb begin
        nxt   = flg_i;
        res_o = reg_i;
        fwe_o = 4'b0000;
        unique case (op)
            OP_ADD, OP_SUB: begin
                res_o = ar_sum;
                nxt   = {ar_sum[MSB], ar_v, (ar_sum == '0), ar_c};
                fwe_o = 4'b1111;
            end
            OP_CMP: begin
                res_o = reg_i;
                nxt   = {ar_sum[MSB], flg_i[FLAG_V], (ar_sum == '0), ar_c};
                fwe_o = 4'b1011;
            end
            OP_INC, OP_DEC: begin
                res_o = ar_sum;
                nxt   = {ar_sum[MSB], flg_i[FLAG_V], (ar_sum == '0), flg_i[FLAG_C]};
                fwe_o = 4'b1010;
            end
            OP_OR, OP_AND, OP_XOR, OP_LOAD, OP_XFER: begin
                res_o = lg_res;
                nxt   = {lg_res[MSB], flg_i[FLAG_V], (lg_res == '0), flg_i[FLAG_C]};
                fwe_o = 4'b1010;
            end
            OP_BIT: begin
                res_o = lg_res;
                nxt   = {mem_i[MSB], mem_i[MSB-1], lg_tz, flg_i[FLAG_C]};
                fwe_o = 4'b1110;
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                res_o = sh_res;
                nxt   = {sh_res[MSB], flg_i[FLAG_V], (sh_res == '0), sh_c};
                fwe_o = 4'b1011;
            end
            OP_QUIET: begin
                res_o = reg_i;
                nxt   = flg_i;
                fwe_o = 4'b0000;
            end
            default: begin
                res_o = reg_i;
                nxt   = flg_i;
                fwe_o = 4'b0000;
            end
        endcase
        flg_o = (fwe_o & nxt) | (~fwe_o & flg_i);
    end

    always_comb begin
        // R11: flags outside the mask repeat the incoming flags
        a_r11_masked_hold: assert ((~fwe_o & flg_o) == (~fwe_o & flg_i))
            else $error("masked flag changed");
        // R10: the quiet move writes no flag and keeps the register value
        if (op == OP_QUIET) begin
            a_r10_quiet: assert (fwe_o == 4'b0000 && res_o == reg_i)
                else $error("quiet move touched flags or data");
        end
        // R9: result-driven zero and negative for loads and transfers
        if (op == OP_LOAD || op == OP_XFER) begin
            a_r9_nz_follow: assert (flg_o[FLAG_Z] == (res_o == '0) && flg_o[FLAG_N] == res_o[MSB])
                else $error("load/transfer N or Z wrong");
        end
    end
endmodule

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
module sim_alu8_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_i = 4'd14;
    logic [7:0] reg_i = 8'h00;
    logic [7:0] mem_i = 8'h00;
    logic [3:0] flg_i = 4'b0000;
    logic [7:0] res_o;
    logic [3:0] flg_o;
    logic [3:0] fwe_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    alu8_core u0 (
        .op_i(op_i), .reg_i(reg_i), .mem_i(mem_i), .flg_i(flg_i),
        .res_o(res_o), .flg_o(flg_o), .fwe_o(fwe_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !done) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic model(input int op, input int r, input int m, input logic [3:0] fi,
                         output int er, output logic [3:0] ef, output logic [3:0] ew,
                         output string tag);
        int c, s, sr, sm, ss;
        logic n, v, z, cy;
        c  = fi[0];
        n  = fi[3]; v = fi[2]; z = fi[1]; cy = fi[0];
        sr = (r > 127) ? r - 256 : r;
        sm = (m > 127) ? m - 256 : m;
        er = r; ew = 4'b0000; tag = "R10";
        case (op)
            0: begin s = r + m + c; ss = sr + sm + c; er = s % 256;
                     cy = (s > 255); v = (ss > 127 || ss < -128); ew = 4'b1111; tag = "R1"; end
            1: begin s = r - m - (1 - c); ss = sr - sm - (1 - c); er = (s + 512) % 256;
                     cy = (s >= 0); v = (ss > 127 || ss < -128); ew = 4'b1111; tag = "R2"; end
            2: begin er = r | m; ew = 4'b1010; tag = "R5"; end
            3: begin er = r & m; ew = 4'b1010; tag = "R5"; end
            4: begin er = r ^ m; ew = 4'b1010; tag = "R5"; end
            5: begin er = r; s = (r - m + 256) % 256; cy = (r >= m); z = (r == m);
                     n = (s >= 128); ew = 4'b1011; tag = "R3"; end
            6: begin er = r; n = (m / 128) % 2; v = (m / 64) % 2; z = ((r & m) == 0);
                     ew = 4'b1110; tag = "R4"; end
            7: begin er = (r * 2) % 256; cy = (r >= 128); ew = 4'b1011; tag = "R6"; end
            8: begin er = r / 2; cy = r % 2; ew = 4'b1011; tag = "R6"; end
            9: begin er = (r * 2) % 256 + c; cy = (r >= 128); ew = 4'b1011; tag = "R7"; end
            10: begin er = r / 2 + 128 * c; cy = r % 2; ew = 4'b1011; tag = "R7"; end
            11: begin er = (r + 1) % 256; ew = 4'b1010; tag = "R8"; end
            12: begin er = (r + 255) % 256; ew = 4'b1010; tag = "R8"; end
            13: begin er = m; ew = 4'b1010; tag = "R9"; end
            15: begin er = r; ew = 4'b1010; tag = "R9"; end
            default: begin er = r; ew = 4'b0000; tag = "R10"; end
        endcase
        if (op != 5 && op != 6 && ew[1]) begin
            z = (er == 0);
            n = (er >= 128);
        end
        ef = {n, v, z, cy};
    endtask

    task automatic apply_check(input int op, input int r, input int m, input logic [3:0] fi);
        int er;
        logic [3:0] ef, ew;
        string tag;
        op_i = op[3:0]; reg_i = r[7:0]; mem_i = m[7:0]; flg_i = fi;
        #1;
        model(op, r, m, fi, er, ef, ew, tag);
        total = total + 1;
        if (res_o !== er[7:0] || flg_o !== ef || fwe_o !== ew) begin
            bad = bad + 1;
            if (bad < 30)
                $display("FAIL %s (R11 merge) op=%0d r=%02h m=%02h fi=%b: actual res=%02h flg=%b we=%b expected res=%02h flg=%b we=%b",
                         tag, op, r, m, fi, res_o, flg_o, fwe_o, er[7:0], ef, ew);
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // quiet move with reset-like inputs: R10
        apply_check(14, 0, 0, 4'b0000);
        // corner points: R1 carry+overflow+zero, R2 borrow, R8 wrap, R4 bit copy
        apply_check(0, 8'h80, 8'h80, 4'b0000);
        apply_check(0, 8'h7F, 8'h00, 4'b0001);
        apply_check(1, 8'h00, 8'h01, 4'b0001);
        apply_check(1, 8'h80, 8'h00, 4'b0000);
        apply_check(11, 8'hFF, 0, 4'b1111);
        apply_check(12, 8'h00, 0, 4'b0000);
        apply_check(6, 8'h00, 8'hC0, 4'b0001);
        apply_check(5, 8'h42, 8'h42, 4'b0100);
        // sweep: every op, every reg value, spread of mem values, both carries
        for (int op = 0; op < 16; op++) begin
            for (int r = 0; r < 256; r++) begin
                for (int k = 0; k < 56; k++) begin
                    int m;
                    logic [3:0] fi;
                    m = (k < 52) ? k * 5 : ((k == 52) ? 8'h7F : ((k == 53) ? 8'h80 : ((k == 54) ? 1 : 8'hFE)));
                    fi = {r[1] ^ m[2], m[0], r[3], 1'b0};
                    apply_check(op, r, m, fi);
                    fi[0] = 1'b1;
                    apply_check(op, r, m, fi);
                end
            end
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule